// File: doc/BRIEF.md
# Banked Memory Mapper with ROM Overlay

This block translates the 16-bit addresses of an 8-bit CPU into physical locations. It works on a 128 KB RAM built from eight 16 KB banks and on two ROM images. Address bits 15:14 pick one of four 16 KB windows. A bank table that can be reconfigured gives each window a RAM bank. Two overlay flags can place a lower ROM over window 0 and an upper ROM over window 3, and they affect reads only. Writes always land in the RAM bank behind the window, so software can fill RAM that is hidden under a ROM.

Software reaches the block through one control strobe that carries a 2-bit function code and a data byte. One code sets the overlay flags and the next video mode, and can also request a one-cycle reset pulse for an external interrupt counter. Another code picks one of eight bank arrangements. The arrangement can only be changed when the static large-memory enable is high. A new control value takes effect on the clock edge that samples it. The address decode itself is combinational from the registered state.

Top module: `bank_mapper`

## Requirements
- R1: After reset the bank arrangement is 0,1,2,3 for windows 0..3. Both ROM overlays are active, `video_mode_o` is 0 and `irq_cnt_rst_o` is 0.
- R2: The window is `cpu_addr_i[15:14]`. `ram_addr_o` is {3-bit bank, `cpu_addr_i[13:0]`}.
- R3: A write with function code 2'b11 loads arrangement `wr_data_i[2:0]`. The banks for windows 0..3 are: 0→0,1,2,3; 1→0,1,2,7; 2→4,5,6,7; 3→0,3,2,7; 4→0,4,2,3; 5→0,5,2,3; 6→0,6,2,3; 7→0,7,2,3.
- R4: While `en_128k_i` is low, arrangement writes are ignored and every window maps to the bank of the same number. Raising the enable later shows the arrangement that was held before.
- R5: A write with function code 2'b10 updates the lower overlay. `wr_data_i[2]`=0 enables it and 1 disables it. While it is enabled, reads in window 0 give `rom_sel_o`=1 and `rom_upper_o`=0.
- R6: In the same 2'b10 write, `wr_data_i[3]`=0 enables the upper overlay and 1 disables it. While it is enabled, reads in window 3 give `rom_sel_o`=1 and `rom_upper_o`=1.
- R7: A CPU write (`cpu_we_i`=1) never selects ROM. It targets the RAM bank of its window.
- R8: A 2'b10 write with `wr_data_i[4]`=1 drives `irq_cnt_rst_o` high for exactly the cycle after the sampling edge.
- R9: A 2'b10 write latches `wr_data_i[1:0]` onto `video_mode_o` at the sampling edge.
- R10: Changing the bank arrangement leaves both overlay flags as they are. A window whose overlay is off reads from its new bank.
- R11: Function codes 2'b00 and 2'b01 change nothing. An access in the same cycle as a control write is decoded with the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_128k_i | input | 1 | Static enable for bank rearrangement |
| wr_valid_i | input | 1 | Control write strobe |
| wr_func_i | input | 2 | Control function code |
| wr_data_i | input | 8 | Control data byte |
| cpu_addr_i | input | 16 | CPU address |
| cpu_we_i | input | 1 | CPU access is a write |
| rom_sel_o | output | 1 | Access is served by ROM |
| rom_upper_o | output | 1 | ROM select refers to the upper image |
| ram_addr_o | output | 17 | Physical RAM address {bank, offset} |
| video_mode_o | output | 2 | Latched next video mode |
| irq_cnt_rst_o | output | 1 | One-cycle interrupt counter reset pulse |

## Verification
A control write and a CPU access can fall in the same cycle. The access has to be decoded with the old overlay and bank state, and the new state has to show on the next cycle. The bench provokes this by holding a write that disables the lower overlay together with a read of window 0. It samples just before the edge and expects ROM, then samples just after the edge and expects RAM. The interrupt pulse and the mode update come from one write, and the bench checks both in the same cycle.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  parameter int unsigned ADDR_W  = 16;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned WIN_W   = 2;
  parameter int unsigned BANK_W  = 3;
  localparam int unsigned NUM_WIN = 1 << WIN_W;
  localparam int unsigned OFF_W   = ADDR_W - WIN_W;
  localparam int unsigned PHYS_W  = BANK_W + OFF_W;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [1:0]        func_t;

  localparam func_t FUNC_ROM_MODE = 2'b10;
  localparam func_t FUNC_RAM_CFG  = 2'b11;

  typedef struct packed {
    bank_t      cfg;
    logic       lo_rom_en;
    logic       hi_rom_en;
    logic [1:0] mode;
    logic       irq_pulse;
  } ctrl_state_t;

  // Bank for a window under a given arrangement; only windows 1 and 3 vary widely.
  function automatic bank_t bank_of(input bank_t cfg, input logic [WIN_W-1:0] win);
    bank_t b;
    case (win)
      2'd0: b = (cfg == 3'd2) ? 3'd4 : 3'd0;
      2'd1: begin
        case (cfg)
          3'd0, 3'd1: b = 3'd1;
          3'd2:       b = 3'd5;
          3'd3:       b = 3'd3;
          default:    b = cfg;
        endcase
      end
      2'd2: b = (cfg == 3'd2) ? 3'd6 : 3'd2;
      default: b = (cfg == 3'd1 || cfg == 3'd2 || cfg == 3'd3) ? 3'd7 : 3'd3;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/bank_mapper_ctrl.sv
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_128k_i,
  input  logic              wr_valid_i,
  input  func_t             wr_func_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_state_t       state_o
);
  ctrl_state_t st_q, st_d;
  logic wr_rom, wr_ram;
  logic unused_data_hi;

  assign unused_data_hi = ^wr_data_i[DATA_W-1:5];
  assign wr_rom = wr_valid_i && (wr_func_i == FUNC_ROM_MODE);
  assign wr_ram = wr_valid_i && (wr_func_i == FUNC_RAM_CFG) && en_128k_i;

  always_comb begin
    st_d = st_q;
    st_d.irq_pulse = 1'b0;
    if (wr_rom) begin
      st_d.lo_rom_en = ~wr_data_i[2];
      st_d.hi_rom_en = ~wr_data_i[3];
      st_d.mode      = wr_data_i[1:0];
      st_d.irq_pulse = wr_data_i[4];
    end
    if (wr_ram) st_d.cfg = wr_data_i[BANK_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.cfg       <= '0;
      st_q.lo_rom_en <= 1'b1;
      st_q.hi_rom_en <= 1'b1;
      st_q.mode      <= 2'd0;
      st_q.irq_pulse <= 1'b0;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/bank_mapper_table.sv
module bank_mapper_table
  import bank_mapper_pkg::*;
(
  input  bank_t cfg_i,
  input  logic  en_128k_i,
  output bank_t banks_o [NUM_WIN]
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [WIN_W-1:0] WIN = WIN_W'(w);
    // Without the enable every window sits on its own-numbered bank.
    assign banks_o[w] = en_128k_i ? bank_of(cfg_i, WIN) : bank_t'(w);
  end
endmodule

// File: rtl/bank_mapper_decode.sv
module bank_mapper_decode
  import bank_mapper_pkg::*;
(
  input  logic              lo_rom_en_i,
  input  logic              hi_rom_en_i,
  input  bank_t             banks_i [NUM_WIN],
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  output logic              rom_sel_o,
  output logic              rom_upper_o,
  output logic [PHYS_W-1:0] ram_addr_o
);
  logic [WIN_W-1:0] win;
  logic             is_lo, is_hi;

  assign win   = cpu_addr_i[ADDR_W-1:OFF_W];
  assign is_lo = (win == '0);
  assign is_hi = (win == {WIN_W{1'b1}});

  // Overlay applies to reads only; writes fall through to RAM.
  assign rom_sel_o   = !cpu_we_i && ((is_lo && lo_rom_en_i) || (is_hi && hi_rom_en_i));
  assign rom_upper_o = rom_sel_o && is_hi;
  assign ram_addr_o  = {banks_i[win], cpu_addr_i[OFF_W-1:0]};
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_128k_i,
  input  logic        wr_valid_i,
  input  logic [1:0]  wr_func_i,
  input  logic [7:0]  wr_data_i,
  input  logic [15:0] cpu_addr_i,
  input  logic        cpu_we_i,
  output logic        rom_sel_o,
  output logic        rom_upper_o,
  output logic [16:0] ram_addr_o,
  output logic [1:0]  video_mode_o,
  output logic        irq_cnt_rst_o
);
  ctrl_state_t st;
  bank_t       banks [NUM_WIN];

  bank_mapper_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_128k_i  (en_128k_i),
    .wr_valid_i (wr_valid_i),
    .wr_func_i  (wr_func_i),
    .wr_data_i  (wr_data_i),
    .state_o    (st)
  );

  bank_mapper_table u_table (
    .cfg_i     (st.cfg),
    .en_128k_i (en_128k_i),
    .banks_o   (banks)
  );

  bank_mapper_decode u_decode (
    .lo_rom_en_i (st.lo_rom_en),
    .hi_rom_en_i (st.hi_rom_en),
    .banks_i     (banks),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_we_i    (cpu_we_i),
    .rom_sel_o   (rom_sel_o),
    .rom_upper_o (rom_upper_o),
    .ram_addr_o  (ram_addr_o)
  );

  assign video_mode_o  = st.mode;
  assign irq_cnt_rst_o = st.irq_pulse;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_128k_i,
  input logic        wr_valid_i,
  input logic [1:0]  wr_func_i,
  input logic [7:0]  wr_data_i,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_we_i,
  input logic        rom_sel_o,
  input logic        rom_upper_o,
  input logic [16:0] ram_addr_o,
  input logic [1:0]  video_mode_o,
  input logic        irq_cnt_rst_o
);
  logic rom_wr;
  assign rom_wr = wr_valid_i && (wr_func_i == 2'b10);

  a_r7_write_to_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i |-> !rom_sel_o);
  a_r2_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_addr_o[13:0] == cpu_addr_i[13:0]);
  a_r4_fixed_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_128k_i |-> ram_addr_o[16:14] == {1'b0, cpu_addr_i[15:14]});
  a_r5_lower_win0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_sel_o && !rom_upper_o) |-> cpu_addr_i[15:14] == 2'd0);
  a_r6_upper_win3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_upper_o |-> (rom_sel_o && cpu_addr_i[15:14] == 2'd3));
  a_r8_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_wr && wr_data_i[4]) |=> irq_cnt_rst_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_wr && wr_data_i[4]) |=> !irq_cnt_rst_o);
  a_r9_mode_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_wr |=> video_mode_o == $past(wr_data_i[1:0]));
endmodule

bind bank_mapper bank_mapper_chk u_chk (.*);

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_128k_i = 1'b1;
  logic        wr_valid_i = 1'b0;
  logic [1:0]  wr_func_i = 2'b00;
  logic [7:0]  wr_data_i = 8'h00;
  logic [15:0] cpu_addr_i = 16'h0000;
  logic        cpu_we_i = 1'b0;
  logic        rom_sel_o, rom_upper_o, irq_cnt_rst_o;
  logic [16:0] ram_addr_o;
  logic [1:0]  video_mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bank_mapper dut_i (.*);

  typedef struct packed {
    logic        do_wr;
    logic [1:0]  func;
    logic [7:0]  data;
    logic        we;
    logic [15:0] addr;
    logic        e_rom;
    logic        e_up;
    logic [16:0] e_ram;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'h00, 1'b0, 16'h0123, 1'b1, 1'b0, 17'h00123, 4'd5},  // R5 reset lower on
    '{1'b0, 2'd0, 8'h00, 1'b0, 16'hC010, 1'b1, 1'b1, 17'h0C010, 4'd6},  // R6
    '{1'b0, 2'd0, 8'h00, 1'b1, 16'h0005, 1'b0, 1'b0, 17'h00005, 4'd7},  // R7
    '{1'b1, 2'd2, 8'h0C, 1'b0, 16'h0123, 1'b0, 1'b0, 17'h00123, 4'd5},  // R5 off
    '{1'b0, 2'd0, 8'h00, 1'b0, 16'hFFFF, 1'b0, 1'b0, 17'h0FFFF, 4'd6},  // R6 off
    '{1'b1, 2'd3, 8'h02, 1'b0, 16'h4000, 1'b0, 1'b0, 17'h14000, 4'd3},  // R3
    '{1'b0, 2'd0, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 17'h10000, 4'd10}, // R10 follows
    '{1'b0, 2'd0, 8'h00, 1'b0, 16'hC001, 1'b0, 1'b0, 17'h1C001, 4'd10},
    '{1'b1, 2'd3, 8'h03, 1'b0, 16'h4002, 1'b0, 1'b0, 17'h0C002, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b0, 16'h8003, 1'b0, 1'b0, 17'h08003, 4'd2},  // R2
    '{1'b1, 2'd2, 8'h00, 1'b0, 16'hC000, 1'b1, 1'b1, 17'h1C000, 4'd6},
    '{1'b1, 2'd3, 8'h04, 1'b0, 16'h0010, 1'b1, 1'b0, 17'h00010, 4'd10}, // R10 overlay kept
    '{1'b0, 2'd0, 8'h00, 1'b0, 16'h4010, 1'b0, 1'b0, 17'h10010, 4'd3},
    '{1'b1, 2'd3, 8'h07, 1'b1, 16'h7FFF, 1'b0, 1'b0, 17'h1FFFF, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b0, 16'hC000, 1'b1, 1'b1, 17'h0C000, 4'd10},
    '{1'b1, 2'd0, 8'h03, 1'b0, 16'h4000, 1'b0, 1'b0, 17'h1C000, 4'd11}, // R11 code ignored
    '{1'b1, 2'd3, 8'h01, 1'b1, 16'hC100, 1'b0, 1'b0, 17'h1C100, 4'd7},
    '{1'b1, 2'd3, 8'h06, 1'b0, 16'h4000, 1'b0, 1'b0, 17'h18000, 4'd3},
    '{1'b1, 2'd3, 8'h05, 1'b0, 16'h4000, 1'b0, 1'b0, 17'h14000, 4'd3},
    '{1'b1, 2'd3, 8'h00, 1'b1, 16'hC000, 1'b0, 1'b0, 17'h0C000, 4'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [1:0] f, input logic [7:0] d);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_func_i = f; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input logic w);
    cpu_addr_i = a; cpu_we_i = w;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    access(16'h0000, 1'b0);
    check("R1 rom_sel", rom_sel_o, 1);
    check("R1 mode", video_mode_o, 0);
    check("R1 irq", irq_cnt_rst_o, 0);
    access(16'hC000, 1'b0);
    check("R1 upper", rom_upper_o, 1);
    access(16'h8000, 1'b0);
    check("R1 bank2", ram_addr_o, 17'h08000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].do_wr) ctrl_write(VECS[i].func, VECS[i].data);
      else @(negedge clk_i);
      access(VECS[i].addr, VECS[i].we);
      check($sformatf("R%0d vec%0d rom", VECS[i].req, i), rom_sel_o, VECS[i].e_rom);
      check($sformatf("R%0d vec%0d up", VECS[i].req, i), rom_upper_o, VECS[i].e_up);
      check($sformatf("R%0d vec%0d ram", VECS[i].req, i), ram_addr_o, VECS[i].e_ram);
    end

    // R8 and R9 from one write, observed in the same cycle
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_func_i = 2'b10; wr_data_i = 8'h13;
    check("R8 no early pulse", irq_cnt_rst_o, 0);
    @(posedge clk_i); #1;
    check("R8 pulse", irq_cnt_rst_o, 1);
    check("R9 mode", video_mode_o, 3);
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    @(posedge clk_i); #1;
    check("R8 pulse ends", irq_cnt_rst_o, 0);
    check("R9 mode held", video_mode_o, 3);
    ctrl_write(2'b10, 8'h01);
    check("R9 mode 1", video_mode_o, 1);
    check("R8 no pulse", irq_cnt_rst_o, 0);

    // R11 same-cycle access sees the old state
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_func_i = 2'b10; wr_data_i = 8'h04;
    access(16'h0100, 1'b0);
    check("R11 old state", rom_sel_o, 1);
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    #1;
    check("R11 new state", rom_sel_o, 0);
    ctrl_write(2'b01, 8'h00);
    access(16'h0100, 1'b0);
    check("R11 code1 ignored", rom_sel_o, 0);

    // R4 enable low
    do_reset();
    en_128k_i = 1'b0;
    ctrl_write(2'b11, 8'h02);
    access(16'h4000, 1'b0);
    check("R4 ignored", ram_addr_o, 17'h04000);
    access(16'hC000, 1'b1);
    check("R4 win3", ram_addr_o, 17'h0C000);
    en_128k_i = 1'b1;
    access(16'h4000, 1'b0);
    check("R4 held config", ram_addr_o, 17'h04000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule